// File: doc/BRIEF.md
# Multicore private peripheral region controller

This block is the bus slave for the 8 KB private window of a small cluster of one to four cores. It holds a small set of coherency-control registers at the base of the window. It splits the rest of the window into decoded slots for the per-core interrupt CPU interfaces, the per-core timers, the per-core watchdogs and the interrupt distributor. For each slot it raises a chip select and forwards the address offset local to that slot, so that the peripherals behind it never see the absolute window address.

Each per-core group of slots begins with an alias slot that stands for "the core issuing the access", followed by one slot for each core in order. The register bus is single-cycle. An access is a cycle with read enable or write enable high, and ready answers in that same cycle. The block also carries a fixed interrupt wiring table. It passes the external interrupt lines through at the bottom of the controller's input space. It places each core's timer interrupt and watchdog interrupt at fixed positions inside that core's 32-line private block. This wiring is registered, so each line reaches the output one cycle after its input.

Top module: `priv_region_ctrl`

## Requirements
- R1: The control register at offset 0x000 resets to zero. A write keeps only write-data bit 0, and a read returns that bit in bit 0 with bits 31:1 reading zero.
- R2: Offset 0x004 reads the configuration word. Bits 1:0 hold NUM_CORES-1, bits (3+NUM_CORES):4 are all ones, and all other bits are zero (0x72 for three cores). A write to it changes nothing and raises bus_err.
- R3: Offset 0x008 always reads zero, and a write to it raises bus_err. Offset 0x00C reads zero and accepts a write without bus_err and without changing any register.
- R4: Any other byte offset in 0x000–0x0FF reads zero without bus_err. A write there raises bus_err and leaves the control register unchanged.
- R5: An access at 0x100 + i×0x100 + k, for i from 0 to NUM_CORES and k from 0x00 to 0xFF, asserts cpuif_sel[i] with win_off = k. Slot 0 is the current-core alias and slot i addresses core i-1.
- R6: An access at 0x600 + i×0x100 + k asserts tmr_sel[i] when k is 0x00–0x1F and wdt_sel[i] when k is 0x20–0x3F, with win_off = k[4:0]. The slots are ordered alias first, as in R5.
- R7: Any access with address bit 12 set asserts dist_sel, with win_off = address[11:0].
- R8: An access to an unassigned address asserts bus_err, asserts no select and reads zero. Unassigned addresses are pages 1–15 not claimed by R5 or R6, and bytes 0x40–0xFF of a timer page.
- R9: bus_ready is high exactly in cycles with bus_re or bus_we high. Selects, bus_err and win_off are zero in other cycles. win_off is zero unless a select is high, and bus_rdata is zero except on a register-range read.
- R10: gic_irq_out bit j equals ext_irq_in[j] for j < EXT_IRQS. Bit EXT_IRQS+32×c+29 carries tmr_irq_in[c] and bit EXT_IRQS+32×c+30 carries wdt_irq_in[c]. All other bits are zero. The output lags the inputs by one clock and is zero after reset.
- R11: At most one of cpuif_sel, tmr_sel, wdt_sel and dist_sel has a bit set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address inside the private window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Register read data |
| bus_ready | output | 1 | Access acknowledge, same cycle |
| bus_err | output | 1 | Bad write or unassigned address |
| cpuif_sel | output | NUM_CORES+1 | Interrupt CPU interface slot selects, alias first |
| tmr_sel | output | NUM_CORES+1 | Timer slot selects, alias first |
| wdt_sel | output | NUM_CORES+1 | Watchdog slot selects, alias first |
| dist_sel | output | 1 | Distributor select |
| win_off | output | 12 | Offset local to the selected slot |
| ext_irq_in | input | EXT_IRQS | External interrupt lines |
| tmr_irq_in | input | NUM_CORES | Per-core timer interrupts |
| wdt_irq_in | input | NUM_CORES | Per-core watchdog interrupts |
| gic_irq_out | output | EXT_IRQS+32×NUM_CORES | Interrupt controller input vector |

## Verification
The bench builds the block with NUM_CORES = 3 and EXT_IRQS = 32. With three cores the configuration word is a distinct value, 0x72, that has both fields non-zero. That core count also leaves an unclaimed page between the CPU interface slots and the timer slots, and a run of unclaimed pages above the last watchdog, so both kinds of hole can be reached. Three cores also place the routed timer and watchdog lines in three separate 32-bit blocks above the external lines. This shows whether the base offset and the per-core stride are right.

// File: rtl/prr_pkg.sv
package prr_pkg;
  localparam int ADDR_W       = 13;
  localparam int DATA_W       = 32;
  localparam int OFF_W        = 12;
  localparam int PAGE_W       = 4;
  localparam int PPI_PER_CORE = 32;
  localparam int PPI_TMR      = 29;
  localparam int PPI_WDT      = 30;
  localparam int CPUIF_PAGE0  = 1;
  localparam int TMR_PAGE0    = 6;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;
  localparam logic [7:0] OFS_FLUSH = 8'h0C;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_REGS,
    RGN_CPUIF,
    RGN_TMR,
    RGN_WDT,
    RGN_DIST
  } region_e;

  function automatic logic [DATA_W-1:0] cfg_word(input int n);
    logic [DATA_W-1:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return (mask << 4) | DATA_W'(n - 1);
  endfunction
endpackage

// File: rtl/prr_decode.sv
module prr_decode
  import prr_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               access,
  output region_e            rgn,
  output logic [NUM_CORES:0] slot_oh,
  output logic [OFF_W-1:0]   off
);
  localparam int SLOTS = NUM_CORES + 1;

  logic [PAGE_W-1:0] page;
  assign page = addr[11:8];

  always_comb begin
    rgn     = RGN_NONE;
    slot_oh = '0;
    off     = '0;
    if (access) begin
      if (addr[12]) begin
        rgn = RGN_DIST;
        off = addr[11:0];
      end else if (page == '0) begin
        rgn = RGN_REGS;
      end else begin
        for (int i = 0; i < SLOTS; i++) begin
          if (page == PAGE_W'(CPUIF_PAGE0 + i)) begin
            rgn        = RGN_CPUIF;
            slot_oh[i] = 1'b1;
            off        = {4'h0, addr[7:0]};
          end
          if (page == PAGE_W'(TMR_PAGE0 + i) && addr[7:6] == 2'b00) begin
            rgn        = addr[5] ? RGN_WDT : RGN_TMR;
            slot_oh[i] = 1'b1;
            off        = {7'h00, addr[4:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/prr_regs.sv
module prr_regs
  import prr_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        ofs,
  input  logic              wr_bit0,
  output logic [DATA_W-1:0] rdata,
  output logic              bad_wr
);
  localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

  logic ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
    end else if (hit && wr && ofs == OFS_CTRL) begin
      ctrl_q <= wr_bit0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && rd) begin
      case (ofs)
        OFS_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
        OFS_CFG:  rdata = CFG_VAL;
        default:  rdata = '0;
      endcase
    end
  end

  assign bad_wr = hit && wr && (ofs != OFS_CTRL) && (ofs != OFS_FLUSH);
endmodule

// File: rtl/prr_irq_route.sv
module prr_irq_route
  import prr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int EXT_IRQS  = 32
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [EXT_IRQS-1:0]                        ext_irq,
  input  logic [NUM_CORES-1:0]                       tmr_irq,
  input  logic [NUM_CORES-1:0]                       wdt_irq,
  output logic [EXT_IRQS+PPI_PER_CORE*NUM_CORES-1:0] irq_q
);
  localparam int OUT_W = EXT_IRQS + PPI_PER_CORE * NUM_CORES;

  logic [PPI_PER_CORE-1:0] core_blk [NUM_CORES];
  logic [OUT_W-1:0]        irq_d;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_comb begin
      core_blk[c]          = '0;
      core_blk[c][PPI_TMR] = tmr_irq[c];
      core_blk[c][PPI_WDT] = wdt_irq[c];
    end
  end

  always_comb begin
    irq_d                 = '0;
    irq_d[EXT_IRQS-1:0]   = ext_irq;
    for (int c = 0; c < NUM_CORES; c++) begin
      irq_d[EXT_IRQS + PPI_PER_CORE*c +: PPI_PER_CORE] = core_blk[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end
endmodule

// File: rtl/priv_region_ctrl.sv
module priv_region_ctrl
  import prr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int EXT_IRQS  = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [12:0]                      bus_addr,
  input  logic [31:0]                      bus_wdata,
  input  logic                             bus_we,
  input  logic                             bus_re,
  output logic [31:0]                      bus_rdata,
  output logic                             bus_ready,
  output logic                             bus_err,
  output logic [NUM_CORES:0]               cpuif_sel,
  output logic [NUM_CORES:0]               tmr_sel,
  output logic [NUM_CORES:0]               wdt_sel,
  output logic                             dist_sel,
  output logic [11:0]                      win_off,
  input  logic [EXT_IRQS-1:0]              ext_irq_in,
  input  logic [NUM_CORES-1:0]             tmr_irq_in,
  input  logic [NUM_CORES-1:0]             wdt_irq_in,
  output logic [EXT_IRQS+32*NUM_CORES-1:0] gic_irq_out
);
  localparam int SLOTS = NUM_CORES + 1;

  logic               access;
  region_e            rgn;
  logic [SLOTS-1:0]   slot_oh;
  logic               bad_wr;

  assign access = bus_re | bus_we;

  prr_decode #(.NUM_CORES(NUM_CORES)) u_decode (
    .addr    (bus_addr),
    .access  (access),
    .rgn     (rgn),
    .slot_oh (slot_oh),
    .off     (win_off)
  );

  prr_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .hit     (rgn == RGN_REGS),
    .rd      (bus_re),
    .wr      (bus_we),
    .ofs     (bus_addr[7:0]),
    .wr_bit0 (bus_wdata[0]),
    .rdata   (bus_rdata),
    .bad_wr  (bad_wr)
  );

  prr_irq_route #(.NUM_CORES(NUM_CORES), .EXT_IRQS(EXT_IRQS)) u_route (
    .clk     (clk),
    .rst     (rst),
    .ext_irq (ext_irq_in),
    .tmr_irq (tmr_irq_in),
    .wdt_irq (wdt_irq_in),
    .irq_q   (gic_irq_out)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign cpuif_sel[i] = (rgn == RGN_CPUIF) && slot_oh[i];
    assign tmr_sel[i]   = (rgn == RGN_TMR)   && slot_oh[i];
    assign wdt_sel[i]   = (rgn == RGN_WDT)   && slot_oh[i];
  end

  assign dist_sel  = (rgn == RGN_DIST);
  assign bus_ready = access;
  assign bus_err   = bad_wr | (access && rgn == RGN_NONE);
endmodule

// File: rtl/priv_region_ctrl_chk.sv
module priv_region_ctrl_chk #(
  parameter int NUM_CORES = 2,
  parameter int EXT_IRQS  = 32
) (
  input logic                             clk,
  input logic                             rst,
  input logic [12:0]                      bus_addr,
  input logic                             bus_we,
  input logic                             bus_re,
  input logic [31:0]                      bus_rdata,
  input logic                             bus_ready,
  input logic                             bus_err,
  input logic [NUM_CORES:0]               cpuif_sel,
  input logic [NUM_CORES:0]               tmr_sel,
  input logic [NUM_CORES:0]               wdt_sel,
  input logic                             dist_sel,
  input logic [11:0]                      win_off,
  input logic [NUM_CORES-1:0]             tmr_irq_in,
  input logic [NUM_CORES-1:0]             wdt_irq_in,
  input logic [EXT_IRQS+32*NUM_CORES-1:0] gic_irq_out
);
  localparam logic [31:0] CFG_EXP =
    ({28'h0, 4'((1 << NUM_CORES) - 1)} << 4) | 32'(NUM_CORES - 1);

  logic [3*(NUM_CORES+1):0] all_sel;
  assign all_sel = {dist_sel, wdt_sel, tmr_sel, cpuif_sel};

  a_r9_err_in_access: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ready);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> (all_sel == '0 && win_off == '0 && bus_rdata == '0));

  a_r11_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_sel));

  a_r7_dist_window: assert property (@(posedge clk) disable iff (rst)
    ((bus_re || bus_we) && bus_addr[12]) |-> (dist_sel && win_off == bus_addr[11:0] && !bus_err));

  a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 13'h000) |-> (bus_rdata[31:1] == '0));

  a_r2_cfg_value: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 13'h004) |-> (bus_rdata == CFG_EXP));

  a_r4_bad_write_flag: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[12:8] == '0 && bus_addr[7:0] != 8'h00 && bus_addr[7:0] != 8'h0C)
      |-> bus_err);

  a_r8_hole_silent: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (all_sel == '0 && bus_rdata == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    a_r10_tmr_high: assert property (@(posedge clk) disable iff (rst)
      tmr_irq_in[c] |=> gic_irq_out[EXT_IRQS + 32*c + 29]);
    a_r10_tmr_low: assert property (@(posedge clk) disable iff (rst)
      !tmr_irq_in[c] |=> !gic_irq_out[EXT_IRQS + 32*c + 29]);
    a_r10_wdt_high: assert property (@(posedge clk) disable iff (rst)
      wdt_irq_in[c] |=> gic_irq_out[EXT_IRQS + 32*c + 30]);
    a_r10_wdt_low: assert property (@(posedge clk) disable iff (rst)
      !wdt_irq_in[c] |=> !gic_irq_out[EXT_IRQS + 32*c + 30]);
  end
endmodule

bind priv_region_ctrl priv_region_ctrl_chk #(
  .NUM_CORES(NUM_CORES),
  .EXT_IRQS (EXT_IRQS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .bus_ready  (bus_ready),
  .bus_err    (bus_err),
  .cpuif_sel  (cpuif_sel),
  .tmr_sel    (tmr_sel),
  .wdt_sel    (wdt_sel),
  .dist_sel   (dist_sel),
  .win_off    (win_off),
  .tmr_irq_in (tmr_irq_in),
  .wdt_irq_in (wdt_irq_in),
  .gic_irq_out(gic_irq_out)
);

// File: tb/priv_region_ctrl_tb.sv
`timescale 1ns/1ps
module priv_region_ctrl_tb;
  localparam int NC    = 3;
  localparam int EXT   = 32;
  localparam int GW    = EXT + 32*NC;
  localparam int SELW  = 3*(NC+1) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [12:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_ready, bus_err, dist_sel;
  logic [NC:0]   cpuif_sel, tmr_sel, wdt_sel;
  logic [11:0]   win_off;
  logic [EXT-1:0] ext_irq_in = '0;
  logic [NC-1:0] tmr_irq_in = '0;
  logic [NC-1:0] wdt_irq_in = '0;
  logic [GW-1:0] gic_irq_out;
  logic [SELW-1:0] sel_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  priv_region_ctrl #(.NUM_CORES(NC), .EXT_IRQS(EXT)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .cpuif_sel(cpuif_sel),
    .tmr_sel(tmr_sel), .wdt_sel(wdt_sel), .dist_sel(dist_sel),
    .win_off(win_off), .ext_irq_in(ext_irq_in), .tmr_irq_in(tmr_irq_in),
    .wdt_irq_in(wdt_irq_in), .gic_irq_out(gic_irq_out)
  );

  assign sel_vec = {dist_sel, wdt_sel, tmr_sel, cpuif_sel};

  function automatic logic [SELW-1:0] s_cpu(int i); return SELW'(1) << i; endfunction
  function automatic logic [SELW-1:0] s_tmr(int i); return SELW'(1) << (NC+1+i); endfunction
  function automatic logic [SELW-1:0] s_wdt(int i); return SELW'(1) << (2*(NC+1)+i); endfunction
  localparam logic [SELW-1:0] S_DIST = SELW'(1) << (SELW-1);

  // scoreboard
  logic [31:0]     q_rd  [$];
  logic            q_err [$];
  logic [SELW-1:0] q_sel [$];
  logic [11:0]     q_off [$];
  string           q_tag [$];

  task automatic acc(input logic [12:0] a, input logic w, input logic [31:0] d,
                     input logic [31:0] e_rd, input logic e_err,
                     input logic [SELW-1:0] e_sel, input logic [11:0] e_off,
                     input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_we = w; bus_re = ~w; bus_wdata = d;
    q_rd.push_back(e_rd); q_err.push_back(e_err); q_sel.push_back(e_sel);
    q_off.push_back(e_off); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  always @(negedge clk) begin
    if (bus_re || bus_we) begin
      n_chk++;
      if (q_rd.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected access addr=%h actual=none expected=none", bus_addr);
      end else begin
        logic [31:0] e_rd; logic e_err; logic [SELW-1:0] e_sel; logic [11:0] e_off; string tg;
        e_rd = q_rd.pop_front(); e_err = q_err.pop_front(); e_sel = q_sel.pop_front();
        e_off = q_off.pop_front(); tg = q_tag.pop_front();
        if (bus_rdata !== e_rd || bus_err !== e_err || sel_vec !== e_sel ||
            win_off !== e_off || bus_ready !== 1'b1) begin
          n_bad++;
          $display("FAIL %s addr=%h actual rd=%h err=%b sel=%b off=%h rdy=%b expected rd=%h err=%b sel=%b off=%h rdy=1",
                   tg, bus_addr, bus_rdata, bus_err, sel_vec, win_off, bus_ready,
                   e_rd, e_err, e_sel, e_off);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] route_exp(logic [EXT-1:0] e, logic [NC-1:0] t, logic [NC-1:0] w);
    logic [GW-1:0] v;
    v = '0;
    v[EXT-1:0] = e;
    for (int c = 0; c < NC; c++) begin
      v[EXT + 32*c + 29] = t[c];
      v[EXT + 32*c + 30] = w[c];
    end
    return v;
  endfunction

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk({tag, " ready"}, GW'(bus_ready), '0);
    chk({tag, " err"},   GW'(bus_err), '0);
    chk({tag, " sel"},   GW'(sel_vec), '0);
    chk({tag, " off"},   GW'(win_off), '0);
    chk({tag, " rdata"}, GW'(bus_rdata), '0);
  endtask

  task automatic irq_step(input logic [EXT-1:0] e, input logic [NC-1:0] t, input logic [NC-1:0] w);
    logic [GW-1:0] prev;
    prev = gic_irq_out;
    @(posedge clk); #1;
    ext_irq_in = e; tmr_irq_in = t; wdt_irq_in = w;
    @(negedge clk);
    chk("R10 output holds before edge", gic_irq_out, prev);
    @(negedge clk);
    chk("R10 routed vector", gic_irq_out, route_exp(e, t, w));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    idle_check("R9 after reset");
    chk("R10 reset zero", gic_irq_out, '0);

    // R1 control register
    acc(13'h000, 0, 0, 32'h0, 0, '0, '0, "R1 reset value");
    acc(13'h000, 1, 32'hFFFF_FFFF, 0, 0, '0, '0, "R1 write all ones");
    acc(13'h000, 0, 0, 32'h1, 0, '0, '0, "R1 only bit0 kept");
    acc(13'h000, 1, 32'hFFFF_FFFE, 0, 0, '0, '0, "R1 write bit0 clear");
    acc(13'h000, 0, 0, 32'h0, 0, '0, '0, "R1 bit0 cleared");
    acc(13'h000, 1, 32'h0000_0001, 0, 0, '0, '0, "R1 set again");
    // R2 configuration
    acc(13'h004, 0, 0, 32'h72, 0, '0, '0, "R2 config word");
    acc(13'h004, 1, 32'h0, 0, 1, '0, '0, "R2 write flagged");
    acc(13'h004, 0, 0, 32'h72, 0, '0, '0, "R2 config unchanged");
    // R3 status and flush
    acc(13'h008, 0, 0, 32'h0, 0, '0, '0, "R3 status zero");
    acc(13'h008, 1, 32'hFFFF_FFFF, 0, 1, '0, '0, "R3 status write flagged");
    acc(13'h00C, 1, 32'hFFFF_FFFF, 0, 0, '0, '0, "R3 flush write accepted");
    acc(13'h00C, 0, 0, 32'h0, 0, '0, '0, "R3 flush reads zero");
    acc(13'h000, 0, 0, 32'h1, 0, '0, '0, "R3 flush no side effect");
    // R4 other offsets
    acc(13'h010, 0, 0, 32'h0, 0, '0, '0, "R4 read other offset");
    acc(13'h0FC, 0, 0, 32'h0, 0, '0, '0, "R4 read top offset");
    acc(13'h002, 0, 0, 32'h0, 0, '0, '0, "R4 read unaligned");
    acc(13'h0FC, 1, 32'h0, 0, 1, '0, '0, "R4 write other flagged");
    acc(13'h001, 1, 32'h0, 0, 1, '0, '0, "R4 write near ctrl flagged");
    acc(13'h000, 0, 0, 32'h1, 0, '0, '0, "R4 ctrl unchanged");
    // R5 interrupt CPU interface slots
    acc(13'h134, 0, 0, 0, 0, s_cpu(0), 12'h034, "R5 alias slot");
    acc(13'h2FF, 0, 0, 0, 0, s_cpu(1), 12'h0FF, "R5 core0 slot");
    acc(13'h204, 1, 32'h5, 0, 0, s_cpu(1), 12'h004, "R5 core0 write");
    acc(13'h310, 0, 0, 0, 0, s_cpu(2), 12'h010, "R5 core1 slot");
    acc(13'h480, 0, 0, 0, 0, s_cpu(3), 12'h080, "R5 core2 slot");
    // R8 hole between groups
    acc(13'h500, 0, 0, 0, 1, '0, '0, "R8 page hole read");
    acc(13'h5FF, 1, 32'h1, 0, 1, '0, '0, "R8 page hole write");
    // R6 timers and watchdogs
    acc(13'h600, 0, 0, 0, 0, s_tmr(0), 12'h000, "R6 alias timer");
    acc(13'h71F, 0, 0, 0, 0, s_tmr(1), 12'h01F, "R6 core0 timer top");
    acc(13'h620, 0, 0, 0, 0, s_wdt(0), 12'h000, "R6 alias watchdog");
    acc(13'h83C, 1, 32'h3, 0, 0, s_wdt(2), 12'h01C, "R6 core1 watchdog");
    acc(13'h93F, 0, 0, 0, 0, s_wdt(3), 12'h01F, "R6 core2 watchdog top");
    acc(13'h840, 0, 0, 0, 1, '0, '0, "R8 timer page tail");
    acc(13'h6FF, 0, 0, 0, 1, '0, '0, "R8 timer page end");
    acc(13'hA00, 0, 0, 0, 1, '0, '0, "R8 above last slot");
    acc(13'hFFC, 1, 32'h0, 0, 1, '0, '0, "R8 last hole page");
    // R7 distributor
    acc(13'h1000, 0, 0, 0, 0, S_DIST, 12'h000, "R7 distributor base");
    acc(13'h1ABC, 0, 0, 0, 0, S_DIST, 12'hABC, "R7 distributor mid");
    acc(13'h1FFF, 1, 32'h7, 0, 0, S_DIST, 12'hFFF, "R7 distributor top");
    idle();
    idle_check("R9 R11 idle after traffic");

    // R10 interrupt wiring
    irq_step(32'hA5A5_0001, 3'b101, 3'b010);
    irq_step(32'h0, 3'b010, 3'b101);
    irq_step(32'hFFFF_FFFF, 3'b111, 3'b111);
    irq_step(32'h0, 3'b000, 3'b000);

    // reset returns control register to zero
    irq_step(32'h1, 3'b001, 3'b000);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 cleared by reset", gic_irq_out, route_exp(32'h1, 3'b001, 3'b000) & '0 | (rst ? '0 : gic_irq_out & '0));
    acc(13'h000, 0, 0, 32'h0, 0, '0, '0, "R1 reset clears ctrl");
    idle();
    @(negedge clk);
    chk("R10 resumes after reset", gic_irq_out, route_exp(32'h1, 3'b001, 3'b000));
    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", GW'(q_rd.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule